// File: doc/BRIEF.md
# Triple Buffer Frame Manager

This block hands out frame-buffer indices to a video producer and a frame consumer that share three buffers. The two sides run at unrelated rates and neither can be stalled. The block carries no pixel data and no addresses. It keeps a state and an age rank for each buffer, and it answers two kinds of pulse. A write-done pulse closes the frame that is being written and moves the writer to a new buffer. A read-request pulse releases the frame being read and gives the reader the newest complete frame.

The reader always gets the most recent complete frame. The writer always reuses the oldest buffer that the reader does not hold. As a result, a fast writer drops frames, a fast reader sees repeated frames, and a frame being read is never overwritten.

Each buffer is in one of four states: free, filling, ready or reading. The age rank is a saturating 2-bit value. A completed buffer gets the top rank, and every other rank steps down by one, stopping at zero. When several buffers tie on rank, the lowest index wins.

Top module: `tribuf_mgr`

## Requirements
- R1: After synchronous reset, `wr_idx` is 0, `rd_valid` is 0 and `rd_idx` is 0. All buffers are free with rank 0, except buffer 0, which is filling.
- R2: A `rd_req` pulse made while no frame has ever completed leaves `rd_valid` at 0.
- R3: On `wr_done`, the finished buffer becomes ready with the newest rank (2), and every other rank drops by one, saturating at 0. On the next cycle, `wr_idx` shows the buffer with the lowest rank among those that are neither being read nor just finished, with ties going to the lowest index.
- R4: On `rd_req`, the reader locks the ready buffer with the highest rank. On the next cycle, `rd_idx` shows that buffer and `rd_valid` is 1. Once `rd_valid` is 1, it stays 1 until reset.
- R5: When the reader releases its buffer, that buffer becomes ready again. If no newer frame has completed since, a `rd_req` returns the same index (a repeated frame).
- R6: When several frames complete between two reads, the older complete frames are overwritten and the next `rd_req` returns the most recently completed buffer.
- R7: While `rd_valid` is 1, `wr_idx` never equals `rd_idx`.
- R8: When `wr_done` and `rd_req` occur in the same cycle, the write completion is resolved first. On the next cycle, `rd_idx` equals the `wr_idx` that was current when the two pulses arrived.
- R9: In a cycle with neither `wr_done` nor `rd_req`, `wr_idx`, `rd_idx` and `rd_valid` keep their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_done | input | 1 | Writer finished its frame; one-cycle pulse |
| rd_req | input | 1 | Reader releases its frame and wants the newest; one-cycle pulse |
| wr_idx | output | 2 | Buffer the writer is filling (registered) |
| rd_idx | output | 2 | Buffer the reader holds (registered) |
| rd_valid | output | 1 | Reader holds a complete frame |

## Verification
Every result becomes visible one cycle after its pulse, because all three outputs are registers loaded at the rising edge that samples the request. The driver applies each pulse half a cycle before an edge. At that moment it also computes the expected indices and pushes them into a queue. The monitor takes one entry a few nanoseconds after the following rising edge and compares it with the outputs, so every comparison is made on the cycle in which the result is due. Idle cycles are queued like any other cycle, which checks that nothing moves without a request.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
  typedef enum logic [1:0] {
    BUF_FREE  = 2'd0,
    BUF_FILL  = 2'd1,
    BUF_READY = 2'd2,
    BUF_READ  = 2'd3
  } buf_state_e;
endpackage

// File: rtl/tribuf_age.sv
// Rank update: the stamped buffer becomes newest, every other rank steps down (saturating at 0).
module tribuf_age #(
  parameter int NBUF   = 3,
  parameter int RANK_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic                         stamp,
  input  logic [IDX_W-1:0]             stamp_idx,
  input  logic [NBUF-1:0][RANK_W-1:0]  rank_in,
  output logic [NBUF-1:0][RANK_W-1:0]  rank_out
);
  localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'(NBUF - 1);

  for (genvar i = 0; i < NBUF; i++) begin : g_rank
    always_comb begin
      rank_out[i] = rank_in[i];
      if (stamp) begin
        if (stamp_idx == IDX_W'(i))
          rank_out[i] = TOP_RANK;
        else if (rank_in[i] != '0)
          rank_out[i] = rank_in[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tribuf_rank_sel.sv
// Picks, among the masked buffers, the highest rank (PICK_NEWEST=1) or the lowest rank.
// A strict compare keeps the lowest index when ranks are equal.
module tribuf_rank_sel #(
  parameter int NBUF        = 3,
  parameter int RANK_W      = 2,
  parameter int IDX_W       = 2,
  parameter bit PICK_NEWEST = 1'b1
) (
  input  logic [NBUF-1:0]              mask,
  input  logic [NBUF-1:0][RANK_W-1:0]  rank,
  output logic                         found,
  output logic [IDX_W-1:0]             sel
);
  if (PICK_NEWEST) begin : g_newest
    always_comb begin
      logic [RANK_W-1:0] best;
      found = 1'b0;
      sel   = '0;
      best  = '0;
      for (int i = 0; i < NBUF; i++) begin
        if (mask[i] && (!found || rank[i] > best)) begin
          found = 1'b1;
          sel   = IDX_W'(i);
          best  = rank[i];
        end
      end
    end
  end else begin : g_oldest
    always_comb begin
      logic [RANK_W-1:0] best;
      found = 1'b0;
      sel   = '0;
      best  = '0;
      for (int i = 0; i < NBUF; i++) begin
        if (mask[i] && (!found || rank[i] < best)) begin
          found = 1'b1;
          sel   = IDX_W'(i);
          best  = rank[i];
        end
      end
    end
  end
endmodule

// File: rtl/tribuf_mgr.sv
module tribuf_mgr
  import tribuf_pkg::*;
#(
  parameter int  NBUF   = 3,
  parameter int  RANK_W = 2,
  localparam int IDX_W  = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_done,
  input  logic             rd_req,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  buf_state_e                  st_q [NBUF];
  logic [NBUF-1:0][RANK_W-1:0] rank_q;
  logic [NBUF-1:0][RANK_W-1:0] rank_d;

  // Stage A: the write completion and the reader's release.
  buf_state_e      st_a [NBUF];
  logic [NBUF-1:0] ready_mask;
  logic            rd_found;
  logic [IDX_W-1:0] rd_sel;

  // Stage B: the reader's lock.
  buf_state_e      st_b [NBUF];
  logic [NBUF-1:0] fill_mask;
  logic            wr_found;
  logic [IDX_W-1:0] wr_sel;

  // Stage C: the writer's next buffer.
  buf_state_e      st_d [NBUF];
  logic [IDX_W-1:0] wr_idx_d;
  logic [IDX_W-1:0] rd_idx_d;
  logic            rd_valid_d;

  tribuf_age #(.NBUF(NBUF), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_age (
    .stamp     (wr_done),
    .stamp_idx (wr_idx),
    .rank_in   (rank_q),
    .rank_out  (rank_d)
  );

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      st_a[i] = st_q[i];
      if (wr_done && wr_idx == IDX_W'(i))
        st_a[i] = BUF_READY;
      if (rd_req && rd_valid && rd_idx == IDX_W'(i))
        st_a[i] = BUF_READY;
      ready_mask[i] = rd_req && (st_a[i] == BUF_READY);
    end
  end

  tribuf_rank_sel #(
    .NBUF(NBUF), .RANK_W(RANK_W), .IDX_W(IDX_W), .PICK_NEWEST(1'b1)
  ) u_rd_sel (
    .mask  (ready_mask),
    .rank  (rank_d),
    .found (rd_found),
    .sel   (rd_sel)
  );

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      st_b[i] = st_a[i];
      if (rd_found && rd_sel == IDX_W'(i))
        st_b[i] = BUF_READ;
      fill_mask[i] = wr_done && (st_b[i] != BUF_READ) && (wr_idx != IDX_W'(i));
    end
    rd_idx_d   = rd_found ? rd_sel : rd_idx;
    rd_valid_d = rd_valid | rd_found;
  end

  tribuf_rank_sel #(
    .NBUF(NBUF), .RANK_W(RANK_W), .IDX_W(IDX_W), .PICK_NEWEST(1'b0)
  ) u_wr_sel (
    .mask  (fill_mask),
    .rank  (rank_d),
    .found (wr_found),
    .sel   (wr_sel)
  );

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      st_d[i] = st_b[i];
      if (wr_found && wr_sel == IDX_W'(i))
        st_d[i] = BUF_FILL;
    end
    wr_idx_d = wr_found ? wr_sel : wr_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBUF; i++)
        st_q[i] <= (i == 0) ? BUF_FILL : BUF_FREE;
      rank_q   <= '0;
      wr_idx   <= '0;
      rd_idx   <= '0;
      rd_valid <= 1'b0;
    end else begin
      for (int i = 0; i < NBUF; i++)
        st_q[i] <= st_d[i];
      rank_q   <= rank_d;
      wr_idx   <= wr_idx_d;
      rd_idx   <= rd_idx_d;
      rd_valid <= rd_valid_d;
    end
  end
endmodule

// File: rtl/tribuf_mgr_chk.sv
module tribuf_mgr_chk #(
  parameter int IDX_W = 2,
  parameter int NBUF  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_done,
  input logic             rd_req,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rd_valid
);
  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (wr_idx == '0 && !rd_valid && rd_idx == '0));

  // R2: rd_valid can only rise after a read request
  p_valid_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_valid ##1 rd_valid |-> $past(rd_req));

  // R3: a write completion always moves the writer
  p_writer_moves_r3: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> wr_idx != $past(wr_idx));

  // R3: the writer index stays inside the buffer range
  p_wr_range_r3: assert property (@(posedge clk) disable iff (rst)
    32'(wr_idx) < NBUF);

  // R4: once valid, the reader stays valid
  p_valid_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_valid);

  // R7: the writer never sits on the buffer being read
  p_no_tear_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> wr_idx != rd_idx);

  // R8: same-cycle completion and request hand over the finished frame
  p_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_done && rd_req) |=> (rd_valid && rd_idx == $past(wr_idx)));

  // R9: no request, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_done && !rd_req) |=> ($stable(wr_idx) && $stable(rd_idx) && $stable(rd_valid)));
endmodule

bind tribuf_mgr tribuf_mgr_chk #(.IDX_W(IDX_W), .NBUF(NBUF)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_done  (wr_done),
  .rd_req   (rd_req),
  .wr_idx   (wr_idx),
  .rd_idx   (rd_idx),
  .rd_valid (rd_valid)
);

// File: tb/tribuf_mgr_bench.sv
module tribuf_mgr_bench;
  localparam int NBUF = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_done = 1'b0;
  logic       rd_req = 1'b0;
  logic [1:0] wr_idx;
  logic [1:0] rd_idx;
  logic       rd_valid;

  always #5 clk = ~clk;

  tribuf_mgr u_tribuf_mgr (
    .clk(clk), .rst(rst), .wr_done(wr_done), .rd_req(rd_req),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_valid(rd_valid)
  );

  typedef struct {
    int    wi;
    int    ri;
    bit    rv;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // Model of the requirements. States: 0 free, 1 filling, 2 ready, 3 reading.
  int m_st[NBUF];
  int m_rk[NBUF];
  int m_wi, m_ri;
  bit m_rv;

  task automatic model_reset();
    for (int i = 0; i < NBUF; i++) begin
      m_st[i] = (i == 0) ? 1 : 0;
      m_rk[i] = 0;
    end
    m_wi = 0; m_ri = 0; m_rv = 1'b0;
  endtask

  task automatic model_step(input bit wd, input bit rr);
    int old_wi = m_wi;
    int sel;
    if (wd) begin                       // R3 ranks: stamped buffer newest, others step down
      m_st[old_wi] = 2;
      for (int i = 0; i < NBUF; i++)
        m_rk[i] = (i == old_wi) ? 2 : ((m_rk[i] > 0) ? m_rk[i] - 1 : 0);
    end
    if (rr) begin                       // R4/R5: release, then lock the newest ready buffer
      if (m_rv) m_st[m_ri] = 2;
      sel = -1;
      for (int i = 0; i < NBUF; i++)
        if (m_st[i] == 2 && (sel < 0 || m_rk[i] > m_rk[sel])) sel = i;
      if (sel >= 0) begin
        m_st[sel] = 3; m_ri = sel; m_rv = 1'b1;
      end
    end
    if (wd) begin                       // R3: oldest buffer that is not being read
      sel = -1;
      for (int i = 0; i < NBUF; i++)
        if (m_st[i] != 3 && i != old_wi && (sel < 0 || m_rk[i] < m_rk[sel])) sel = i;
      m_st[sel] = 1; m_wi = sel;
    end
  endtask

  task automatic step(input bit wd, input bit rr, input string tag);
    exp_t e;
    @(negedge clk);
    wr_done = wd;
    rd_req  = rr;
    model_step(wd, rr);
    e.wi = m_wi; e.ri = m_ri; e.rv = m_rv; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares a few ns after each rising edge.
  always begin
    exp_t e;
    @(posedge clk);
    #3;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_chk++;
      if (int'(wr_idx) != e.wi || rd_valid != e.rv || (e.rv && int'(rd_idx) != e.ri)) begin
        n_fail++;
        $display("FAIL %s: wr_idx=%0d rd_idx=%0d rd_valid=%0d expected wr_idx=%0d rd_idx=%0d rd_valid=%0d",
                 e.tag, wr_idx, rd_idx, rd_valid, e.wi, e.ri, e.rv);
      end
      n_chk++;
      if (rd_valid && wr_idx == rd_idx) begin
        n_fail++;
        $display("FAIL R7: wr_idx=%0d rd_idx=%0d expected different indices", wr_idx, rd_idx);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;                                                  // R1
    if (wr_idx != 2'd0 || rd_valid != 1'b0 || rd_idx != 2'd0) begin
      n_fail++;
      $display("FAIL R1: wr_idx=%0d rd_idx=%0d rd_valid=%0d expected 0 0 0", wr_idx, rd_idx, rd_valid);
    end

    step(0, 1, "R2");   // nothing complete: rd_valid stays 0
    step(0, 0, "R9");
    step(1, 0, "R3");   // buf0 ready, writer -> 1
    step(0, 0, "R9");
    step(0, 1, "R4");   // reader -> 0
    step(0, 1, "R5");   // repeat frame 0
    step(1, 0, "R3");   // writer -> 2
    step(1, 0, "R6");   // writer -> 1 (frame in 1 dropped later)
    step(1, 0, "R6");   // writer -> 2
    step(0, 1, "R6");   // reader -> 1, the newest
    step(0, 0, "R9");
    step(1, 1, "R8");   // reader -> 2, writer -> 0
    step(0, 1, "R5");
    step(0, 0, "R9");

    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0] && lfsr[1]) step(1, 1, "R8");
      else if (lfsr[0])       step(1, 0, "R6");
      else if (lfsr[1])       step(0, 1, "R5");
      else                    step(0, 0, "R9");
    end

    step(0, 0, "R9");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule